// File: doc/BRIEF.md
# Low-Power Mode Controller

This block is the mode sequencer of a processor subsystem's power manager. It tracks which of seven operating modes the subsystem is in: normal-high, normal-low, doze-high, doze-low, sleep, deep-sleep and power-down. It publishes that mode as a one-hot vector that the clock and supply logic around it can decode directly. Software selects a mode by writing a 2-bit mode field together with a clock-reduce bit and a timer-select bit. The controller then takes the subsystem back to full speed on its own when wake conditions appear.

The wake conditions come in two kinds. Two qualified request terms cover communication activity and the power-save bit, and each is gated by its own enable. Interrupt terms cover a set of external IRQ lines and a set of timer sources. Leaving a reduced mode costs a fixed number of clock cycles, and that number depends on the mode being left. Counters stand in for oscillator and PLL restart. Each wake-up that completes gives a single-cycle pulse. A power-fail indication sends the controller to power-down, where the main-power gate output is driven. Only a hard reset can leave power-down.

Top module: `lpm_ctrl`

## Requirements
- R1: While `hard_rst_i` is high at a rising edge, the next cycle shows normal-high (`mode_o` = 7'b0000001), `pwr_gate_o` = 0 and `wake_done_o` = 0, and any wake-up in progress is discarded.
- R2: In normal-high or normal-low, a cycle with `mode_wr_i` = 1 moves the controller in the next cycle to a mode decoded from the other inputs, using the one-hot bit of each mode:
  - Field 00 gives normal-high (bit 0) when `clk_reduce_i` = 0, or normal-low (bit 1) when it is 1.
  - Field 01 gives doze-high (bit 2) or doze-low (bit 3), chosen by `clk_reduce_i` in the same way.
  - Field 10 gives sleep (bit 4).
  - Field 11 gives deep-sleep (bit 5) when `timer_sel_i` = 1, or power-down (bit 6) when it is 0.
- R3: A mode write in any state other than normal-high and normal-low has no effect on `mode_o`.
- R4: `pwr_fail_i` = 1 at a rising edge gives power-down in the next cycle, from any state and even during a wake-up. That wake-up then produces no `wake_done_o` pulse.
- R5: Power-down is left only through hard reset. Interrupts, request terms and mode writes leave it unchanged. `pwr_gate_o` is 1 exactly while in power-down.
- R6: The activity term is `comm_act_i & act_req_en_i`. The power-save term is `~pwr_save_i & pwr_req_en_i`. The interrupt term is the OR of every bit of `ext_irq_i` and `tmr_irq_i`.
- R7: Normal-low returns to normal-high in the next cycle when any of the three terms is true or `clk_reduce_i` = 0. Normal-high with no write falls back to normal-low when `clk_reduce_i` = 1 and all three terms are false.
- R8: Doze-high moves to doze-low in the next cycle when the activity term is true, `clk_reduce_i` = 1 and no interrupt is present. The activity term alone, without `clk_reduce_i`, does not wake doze-high.
- R9: A wake event starts a wake-up, which ends in normal-high exactly L cycles after the event edge:
  - The event is the interrupt term in doze-high, sleep or deep-sleep.
  - The event is any of the three terms in doze-low.
  - L is `DOZE_LAT` for either doze mode, `SLEEP_LAT` for sleep and `DEEP_LAT` for deep-sleep.
- R10: `wake_done_o` is high for exactly one cycle: the first cycle in normal-high after a completed wake-up. It is low at all other times.
- R11: `mode_o` always has exactly one bit set.
- R12: During a wake-up, `mode_o` holds the reduced mode. Mode writes and further wake inputs are ignored until the wake-up completes, unless power fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| hard_rst_i | input | 1 | Synchronous hard reset, active high |
| mode_wr_i | input | 1 | Software mode-write strobe |
| mode_sel_i | input | 2 | Requested mode field |
| clk_reduce_i | input | 1 | Clock-source reduce bit (1 = low-speed variant) |
| timer_sel_i | input | 1 | Deep-sleep (1) / power-down (0) select for field 11 |
| act_req_en_i | input | 1 | Enable of the communication-activity request |
| pwr_req_en_i | input | 1 | Enable of the power-save request |
| comm_act_i | input | 1 | Communication activity present |
| pwr_save_i | input | 1 | Processor power-save bit |
| ext_irq_i | input | IRQ_N | External interrupt lines |
| tmr_irq_i | input | TMR_N | Timer interrupt sources |
| pwr_fail_i | input | 1 | Power-fail indication |
| mode_o | output | 7 | One-hot current mode |
| pwr_gate_o | output | 1 | Main-power gate drive, high in power-down |
| wake_done_o | output | 1 | One-cycle wake-complete pulse |

## Verification
The hardest conditions to reach are those that arise only inside a wake-up countdown. These are a mode write landing on a waking controller, and a power failure or hard reset cutting a long deep-sleep countdown short. Neither leaves a trace unless the pulse that should follow is watched for its whole window.

The bench reaches these conditions by entering every reduced mode through a software write and then waking it from each of the twelve interrupt sources in turn. It pulses a write on the first countdown cycle and counts the cycles until normal-high appears. It also injects power-fail or reset partway through a deep-sleep or sleep wake-up and confirms that no wake-complete pulse appears for longer than the full latency.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

   localparam int unsigned NUM_MODES = 7;

   typedef enum logic [2:0] {
      M_NHI = 3'd0,
      M_NLO = 3'd1,
      M_DZH = 3'd2,
      M_DZL = 3'd3,
      M_SLP = 3'd4,
      M_DSL = 3'd5,
      M_PDN = 3'd6
   } lpm_mode_e;

   typedef enum logic [1:0] {
      LAT_DOZE  = 2'd0,
      LAT_SLEEP = 2'd1,
      LAT_DEEP  = 2'd2
   } lpm_lat_e;

   typedef struct packed {
      logic act;
      logic psv;
      logic intr;
   } lpm_terms_t;

endpackage

// File: rtl/lpm_field_decode.sv
module lpm_field_decode
   import lpm_pkg::*;
#(
   parameter int unsigned FIELD_W = 2
) (
   input  logic [FIELD_W-1:0] sel_i,
   input  logic               reduce_i,
   input  logic               tsel_i,
   output lpm_mode_e          target_o
);

   generate
      if (FIELD_W != 2) begin : g_bad_width
         $error("lpm_field_decode: FIELD_W must be 2");
      end
   endgenerate

   always_comb begin
      unique case (sel_i)
         2'b00:   target_o = reduce_i ? M_NLO : M_NHI;
         2'b01:   target_o = reduce_i ? M_DZL : M_DZH;
         2'b10:   target_o = M_SLP;
         default: target_o = tsel_i ? M_DSL : M_PDN;
      endcase
   end

endmodule

// File: rtl/lpm_req_qual.sv
module lpm_req_qual
   import lpm_pkg::*;
#(
   parameter int unsigned IRQ_N = 8,
   parameter int unsigned TMR_N = 4
) (
   input  logic             comm_act_i,
   input  logic             act_en_i,
   input  logic             pwr_save_i,
   input  logic             pwr_en_i,
   input  logic [IRQ_N-1:0] ext_irq_i,
   input  logic [TMR_N-1:0] tmr_irq_i,
   output lpm_terms_t       terms_o
);

   localparam int unsigned SRC_N = IRQ_N + TMR_N;

   generate
      if (IRQ_N < 1) begin : g_bad_irq
         $error("lpm_req_qual: IRQ_N must be at least 1");
      end
      if (TMR_N < 1) begin : g_bad_tmr
         $error("lpm_req_qual: TMR_N must be at least 1");
      end
   endgenerate

   logic [SRC_N-1:0] src_vec;

   genvar gi;
   generate
      for (gi = 0; gi < IRQ_N; gi++) begin : g_ext
         assign src_vec[gi] = ext_irq_i[gi];
      end
      for (gi = 0; gi < TMR_N; gi++) begin : g_tmr
         assign src_vec[IRQ_N+gi] = tmr_irq_i[gi];
      end
   endgenerate

   always_comb begin
      terms_o.act  = comm_act_i & act_en_i;
      terms_o.psv  = ~pwr_save_i & pwr_en_i;
      terms_o.intr = |src_vec;
   end

endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer
   import lpm_pkg::*;
#(
   parameter int unsigned DOZE_LAT  = 3,
   parameter int unsigned SLEEP_LAT = 4,
   parameter int unsigned DEEP_LAT  = 500
) (
   input  logic     clk_i,
   input  logic     hard_rst_i,
   input  logic     start_i,
   input  lpm_lat_e sel_i,
   input  logic     abort_i,
   output logic     busy_o,
   output logic     expire_o
);

   localparam int unsigned MAX_A   = (DOZE_LAT > SLEEP_LAT) ? DOZE_LAT : SLEEP_LAT;
   localparam int unsigned MAX_LAT = (MAX_A > DEEP_LAT) ? MAX_A : DEEP_LAT;
   localparam int unsigned CNT_W   = (MAX_LAT < 2) ? 1 : $clog2(MAX_LAT);

   generate
      if (DOZE_LAT < 1 || SLEEP_LAT < 1 || DEEP_LAT < 1) begin : g_bad_lat
         $error("lpm_wake_timer: every latency must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] load_val;
   logic             busy_q;

   always_comb begin
      unique case (sel_i)
         LAT_DOZE:  load_val = CNT_W'(DOZE_LAT - 1);
         LAT_SLEEP: load_val = CNT_W'(SLEEP_LAT - 1);
         default:   load_val = CNT_W'(DEEP_LAT - 1);
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (hard_rst_i || abort_i) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (start_i && !busy_q) begin
         busy_q <= 1'b1;
         cnt_q  <= load_val;
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign busy_o   = busy_q;
   assign expire_o = busy_q && (cnt_q == '0);

   // R9: an expiring count ends the wake-up on the following cycle
   a_r9_expire_ends: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      (expire_o && !abort_i) |=> !busy_o);

   // R4: an abort empties the timer
   a_r4_abort_clears: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      abort_i |=> !busy_o);

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
   import lpm_pkg::*;
#(
   parameter int unsigned IRQ_N     = 8,
   parameter int unsigned TMR_N     = 4,
   parameter int unsigned DOZE_LAT  = 3,
   parameter int unsigned SLEEP_LAT = 4,
   parameter int unsigned DEEP_LAT  = 500
) (
   input  logic                 clk_i,
   input  logic                 hard_rst_i,
   input  logic                 mode_wr_i,
   input  logic [1:0]           mode_sel_i,
   input  logic                 clk_reduce_i,
   input  logic                 timer_sel_i,
   input  logic                 act_req_en_i,
   input  logic                 pwr_req_en_i,
   input  logic                 comm_act_i,
   input  logic                 pwr_save_i,
   input  logic [IRQ_N-1:0]     ext_irq_i,
   input  logic [TMR_N-1:0]     tmr_irq_i,
   input  logic                 pwr_fail_i,
   output logic [NUM_MODES-1:0] mode_o,
   output logic                 pwr_gate_o,
   output logic                 wake_done_o
);

   lpm_terms_t terms;
   lpm_mode_e  target;
   lpm_mode_e  st_q, st_d;
   logic       done_q, done_d;
   logic       wk_start, wk_busy, wk_expire;
   lpm_lat_e   wk_sel;
   logic       any_term;

   lpm_req_qual #(
      .IRQ_N (IRQ_N),
      .TMR_N (TMR_N)
   ) u_qual (
      .comm_act_i (comm_act_i),
      .act_en_i   (act_req_en_i),
      .pwr_save_i (pwr_save_i),
      .pwr_en_i   (pwr_req_en_i),
      .ext_irq_i  (ext_irq_i),
      .tmr_irq_i  (tmr_irq_i),
      .terms_o    (terms)
   );

   lpm_field_decode #(
      .FIELD_W (2)
   ) u_dec (
      .sel_i    (mode_sel_i),
      .reduce_i (clk_reduce_i),
      .tsel_i   (timer_sel_i),
      .target_o (target)
   );

   lpm_wake_timer #(
      .DOZE_LAT  (DOZE_LAT),
      .SLEEP_LAT (SLEEP_LAT),
      .DEEP_LAT  (DEEP_LAT)
   ) u_wake (
      .clk_i      (clk_i),
      .hard_rst_i (hard_rst_i),
      .start_i    (wk_start),
      .sel_i      (wk_sel),
      .abort_i    (pwr_fail_i),
      .busy_o     (wk_busy),
      .expire_o   (wk_expire)
   );

   assign any_term = terms.act | terms.psv | terms.intr;

   always_comb begin
      st_d     = st_q;
      done_d   = 1'b0;
      wk_start = 1'b0;
      wk_sel   = LAT_DOZE;
      if (pwr_fail_i) begin
         st_d = M_PDN;
      end else if (wk_busy) begin
         if (wk_expire) begin
            st_d   = M_NHI;
            done_d = 1'b1;
         end
      end else begin
         unique case (st_q)
            M_NHI: begin
               if (mode_wr_i)                      st_d = target;
               else if (clk_reduce_i && !any_term) st_d = M_NLO;
            end
            M_NLO: begin
               if (mode_wr_i)                      st_d = target;
               else if (any_term || !clk_reduce_i) st_d = M_NHI;
            end
            M_DZH: begin
               if (terms.intr) begin
                  wk_start = 1'b1;
                  wk_sel   = LAT_DOZE;
               end else if (terms.act && clk_reduce_i) begin
                  st_d = M_DZL;
               end
            end
            M_DZL: begin
               if (any_term) begin
                  wk_start = 1'b1;
                  wk_sel   = LAT_DOZE;
               end
            end
            M_SLP: begin
               if (terms.intr) begin
                  wk_start = 1'b1;
                  wk_sel   = LAT_SLEEP;
               end
            end
            M_DSL: begin
               if (terms.intr) begin
                  wk_start = 1'b1;
                  wk_sel   = LAT_DEEP;
               end
            end
            default: st_d = M_PDN;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (hard_rst_i) begin
         st_q   <= M_NHI;
         done_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= done_d;
      end
   end

   genvar gm;
   generate
      for (gm = 0; gm < NUM_MODES; gm++) begin : g_mode
         assign mode_o[gm] = (st_q == lpm_mode_e'(3'(gm)));
      end
   endgenerate

   assign pwr_gate_o  = (st_q == M_PDN);
   assign wake_done_o = done_q;

   // R1: hard reset lands in normal-high with quiet outputs
   a_r1_reset_to_nhi: assert property (@(posedge clk_i)
      hard_rst_i |=> (mode_o[M_NHI] && !wake_done_o && !pwr_gate_o));

   // R4: power failure forces power-down
   a_r4_fail_forces_pdn: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      pwr_fail_i |=> (mode_o[M_PDN] && pwr_gate_o));

   // R5: power-down is sticky until reset
   a_r5_pdn_sticky: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      mode_o[M_PDN] |=> (mode_o[M_PDN] && pwr_gate_o));

   // R11: exactly one mode at a time
   a_r11_onehot: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      $countones(mode_o) == 1);

   // R10: wake-complete is one cycle wide and only in normal-high
   a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      wake_done_o |=> !wake_done_o);
   a_r10_pulse_in_nhi: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      wake_done_o |-> mode_o[M_NHI]);

   // R12: a wake-up in progress freezes the mode
   a_r12_hold_waking: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      (wk_busy && !wk_expire && !pwr_fail_i) |=> $stable(mode_o));

   // R3: sleep ignores writes when no interrupt is present
   a_r3_sleep_ignores_write: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      (mode_o[M_SLP] && !wk_busy && !terms.intr && !pwr_fail_i) |=> mode_o[M_SLP]);

   // R8: activity with clock reduce moves doze-high to doze-low
   a_r8_dzh_to_dzl: assert property (@(posedge clk_i) disable iff (hard_rst_i)
      (mode_o[M_DZH] && !wk_busy && terms.act && !terms.intr && clk_reduce_i && !pwr_fail_i)
      |=> mode_o[M_DZL]);

endmodule

// File: tb/sim_lpm_ctrl.sv
module sim_lpm_ctrl;

   localparam int IRQ_N     = 8;
   localparam int TMR_N     = 4;
   localparam int DOZE_LAT  = 3;
   localparam int SLEEP_LAT = 4;
   localparam int DEEP_LAT  = 500;

   logic             clk = 1'b0;
   logic             hard_rst;
   logic             mode_wr;
   logic [1:0]       mode_sel;
   logic             clk_reduce, timer_sel;
   logic             act_en, pwr_en, comm_act, pwr_save;
   logic [IRQ_N-1:0] ext_irq;
   logic [TMR_N-1:0] tmr_irq;
   logic             pwr_fail;
   logic [6:0]       mode;
   logic             pwr_gate, wake_done;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   lpm_ctrl #(
      .IRQ_N(IRQ_N), .TMR_N(TMR_N),
      .DOZE_LAT(DOZE_LAT), .SLEEP_LAT(SLEEP_LAT), .DEEP_LAT(DEEP_LAT)
   ) u0 (
      .clk_i(clk), .hard_rst_i(hard_rst), .mode_wr_i(mode_wr), .mode_sel_i(mode_sel),
      .clk_reduce_i(clk_reduce), .timer_sel_i(timer_sel), .act_req_en_i(act_en),
      .pwr_req_en_i(pwr_en), .comm_act_i(comm_act), .pwr_save_i(pwr_save),
      .ext_irq_i(ext_irq), .tmr_irq_i(tmr_irq), .pwr_fail_i(pwr_fail),
      .mode_o(mode), .pwr_gate_o(pwr_gate), .wake_done_o(wake_done)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle_inputs;
      mode_wr = 0; mode_sel = 2'b00; clk_reduce = 0; timer_sel = 1;
      act_en = 0; pwr_en = 0; comm_act = 0; pwr_save = 1;
      ext_irq = '0; tmr_irq = '0; pwr_fail = 0;
   endtask

   task automatic do_reset;
      idle_inputs();
      hard_rst = 1;
      step(1);
      hard_rst = 0;
   endtask

   task automatic sw_write(input int sel, input int csr, input int ts);
      mode_sel = 2'(sel); clk_reduce = csr[0]; timer_sel = ts[0];
      mode_wr = 1;
      step(1);
      mode_wr = 0;
   endtask

   function automatic int exp_idx(input int sel, input int csr, input int ts);
      if (sel == 0) return csr;
      if (sel == 1) return 2 + csr;
      if (sel == 2) return 4;
      return ts ? 5 : 6;
   endfunction

   function automatic int lat_of(input int idx);
      if (idx == 4) return SLEEP_LAT;
      if (idx == 5) return DEEP_LAT;
      return DOZE_LAT;
   endfunction

   task automatic set_src(input int src, input logic v);
      if (src < IRQ_N) ext_irq[src] = v;
      else tmr_irq[src-IRQ_N] = v;
   endtask

   // R9 R10 R12: wake a reduced mode from one interrupt source and time it
   task automatic wake_check(input int idx, input int src);
      int lat;
      lat = lat_of(idx);
      clk_reduce = 0;
      set_src(src, 1'b1);
      step(1);
      set_src(src, 1'b0);
      check("R9 still reduced at event edge", int'(mode), 1 << idx);
      for (int k = 1; k < lat; k++) begin
         if (k == 1) begin mode_sel = 2'b10; mode_wr = 1; end
         step(1);
         mode_wr = 0;
         if (k == 1) check("R12 write ignored while waking", int'(mode), 1 << idx);
         if (wake_done) check("R10 early wake pulse", 1, 0);
      end
      step(1);
      check("R9 normal-high after latency", int'(mode), 1);
      check("R10 wake pulse high", int'(wake_done), 1);
      step(1);
      check("R10 wake pulse one cycle", int'(wake_done), 0);
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         fails++;
         $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int seen;
      hard_rst = 1;
      idle_inputs();
      step(2);
      hard_rst = 0;
      check("R1 reset mode", int'(mode), 1);
      check("R1 reset gate", int'(pwr_gate), 0);
      check("R1 reset pulse", int'(wake_done), 0);

      // R2 R3 R5: sweep every write encoding from normal-high
      for (int sel = 0; sel < 4; sel++)
         for (int csr = 0; csr < 2; csr++)
            for (int ts = 0; ts < 2; ts++) begin
               int e;
               do_reset();
               e = exp_idx(sel, csr, ts);
               sw_write(sel, csr, ts);
               check("R2 decoded mode", int'(mode), 1 << e);
               check("R5 gate follows power-down", int'(pwr_gate), (e == 6) ? 1 : 0);
               if (e >= 2) begin
                  sw_write(0, 0, 1);
                  check("R3 write ignored in reduced mode", int'(mode), 1 << e);
               end
            end

      // R5: power-down ignores everything but reset
      do_reset();
      sw_write(3, 0, 0);
      ext_irq = '1; tmr_irq = '1; comm_act = 1; act_en = 1; pwr_en = 1; pwr_save = 0;
      sw_write(0, 0, 1);
      step(4);
      check("R5 power-down held", int'(mode), 64);
      check("R5 gate held", int'(pwr_gate), 1);
      hard_rst = 1; step(1); hard_rst = 0;
      check("R1 reset leaves power-down", int'(mode), 1);
      check("R5 gate released", int'(pwr_gate), 0);

      // R9 R10 R12: each reduced mode woken from each interrupt source
      for (int idx = 2; idx < 6; idx++)
         for (int src = 0; src < IRQ_N + TMR_N; src++) begin
            do_reset();
            if (idx == 2) sw_write(1, 0, 1);
            else if (idx == 3) sw_write(1, 1, 1);
            else if (idx == 4) sw_write(2, 0, 1);
            else sw_write(3, 0, 1);
            wake_check(idx, src);
         end

      // R6 R7: normal-low and its qualified return terms
      do_reset();
      sw_write(0, 1, 1);
      check("R7 normal-low entered", int'(mode), 2);
      comm_act = 1; step(1);
      check("R6 activity without enable ignored", int'(mode), 2);
      act_en = 1; step(1);
      check("R7 activity returns to high", int'(mode), 1);
      comm_act = 0; act_en = 0; step(1);
      check("R7 falls back to low", int'(mode), 2);
      pwr_save = 0; step(1);
      check("R6 power-save without enable ignored", int'(mode), 2);
      pwr_en = 1; step(1);
      check("R7 power-save term returns to high", int'(mode), 1);
      pwr_save = 1; pwr_en = 0; step(1);
      check("R7 falls back again", int'(mode), 2);
      tmr_irq[2] = 1; step(1);
      check("R7 interrupt returns to high", int'(mode), 1);
      tmr_irq[2] = 0; step(1);
      check("R7 low after interrupt clears", int'(mode), 2);
      clk_reduce = 0; step(1);
      check("R7 clock-reduce cleared gives high", int'(mode), 1);
      step(2);
      check("R7 high stays without reduce", int'(mode), 1);

      // R8 R6: doze-high to doze-low, then power-save wake
      do_reset();
      sw_write(1, 0, 1);
      comm_act = 1; act_en = 1; step(1);
      check("R8 activity without reduce keeps doze-high", int'(mode), 4);
      act_en = 0; clk_reduce = 1; step(1);
      check("R6 disabled activity keeps doze-high", int'(mode), 4);
      act_en = 1; step(1);
      check("R8 doze-high to doze-low", int'(mode), 8);
      comm_act = 0; act_en = 0; step(2);
      check("R8 doze-low stable", int'(mode), 8);
      pwr_en = 1; pwr_save = 0; step(1);
      pwr_en = 0; pwr_save = 1;
      step(DOZE_LAT - 1);
      check("R9 doze-low still waking", int'(mode), 8);
      step(1);
      check("R9 doze-low woke to high", int'(mode), 1);
      check("R10 pulse after doze-low wake", int'(wake_done), 1);
      step(1);
      check("R7 reduce set sends high to low", int'(mode), 2);

      // R4: power fail from normal-high and mid deep-sleep wake
      do_reset();
      pwr_fail = 1; step(1); pwr_fail = 0;
      check("R4 fail from normal-high", int'(mode), 64);
      do_reset();
      sw_write(3, 0, 1);
      ext_irq[5] = 1; step(1); ext_irq[5] = 0;
      step(10);
      pwr_fail = 1; step(1); pwr_fail = 0;
      check("R4 fail during wake", int'(mode), 64);
      seen = 0;
      for (int k = 0; k < DEEP_LAT + 10; k++) begin
         step(1);
         if (wake_done) seen++;
      end
      check("R4 aborted wake gives no pulse", seen, 0);
      check("R4 still power-down", int'(mode), 64);

      // R1: reset during a sleep wake discards it
      do_reset();
      sw_write(2, 0, 1);
      tmr_irq[0] = 1; step(1); tmr_irq[0] = 0;
      hard_rst = 1; step(1); hard_rst = 0;
      check("R1 reset during wake", int'(mode), 1);
      seen = 0;
      for (int k = 0; k < SLEEP_LAT + 4; k++) begin
         step(1);
         if (wake_done) seen++;
      end
      check("R1 no pulse after reset", seen, 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule